// File: doc/BRIEF.md
# I2C Memory-Mapped Target with Interleaved Parity Mode

This block is an I2C target that lets a host controller read and write a flat 16-bit byte address space. The low part of that space is a 3000-byte data buffer, the top part is a bank of 16-bit control registers, and everything between is reserved. The block samples SCL and SDA with the system clock, recognises START and STOP, and answers only when the 7-bit device address it receives matches a fixed upper nibble of `0011` followed by three strap pins. It then takes a two-byte memory address, most significant byte first, and auto-increments through the data bytes that follow. Reads use a repeated START with the R/W bit set and run until the controller NACKs.

Toward the inside of the chip the block drives a plain byte-wide memory port: one write strobe with address and data, one read strobe whose data is expected on `mem_rdata` in the following clock cycle. Writes are staged so that a transfer carrying a single data byte never reaches memory, and so that bytes running over an address range boundary are dropped.

When the parity mode input is set, every transfer is exactly two address bytes and two data bytes followed by a check byte. The check byte makes each bit position even across the address bytes, the data bytes and itself. On writes the controller sends it and the data is committed only when it matches; on reads the target computes and appends it.

Top module: `i2cp_target`

## Requirements
- R1: The target acknowledges a device address byte only when its upper seven bits equal `0011` followed by `strap[2:0]` (bit 0 of the byte is R/W, 0 = write); with all straps low the address is 0x18. A non-matching transfer is not acknowledged and causes no memory access.
- R2: In a write, the first two bytes after the device address form the memory address (high byte first) and data byte n is written to that address plus n.
- R3: A write transfer that carries exactly one data byte produces no memory write.
- R4: The buffer is 0x0000 to 0x0BB7, registers are 0xFFDA to 0xFFFF, and 0x0BB8 to 0xFFD9 is reserved. No write is issued to a reserved address, and once a write's byte address leaves the range its first data byte fell in (including the wrap from 0xFFFF to 0x0000), that byte and all later ones in the transfer are dropped.
- R5: After a repeated START with R/W = 1, the target returns bytes from the current address, incrementing, until the controller NACKs; it then leaves SDA released until the next START.
- R6: In parity mode a write with a correct check byte writes both data bytes to the address and address plus one; any byte after the check byte is ignored.
- R7: In parity mode a write whose check byte is wrong writes nothing and raises `bip_err` for exactly one clock cycle; `bip_err` is never raised outside parity mode.
- R8: In parity mode a read returns the two data bytes and then a check byte equal to the XOR of address high, address low and the two data bytes.
- R9: The memory port never asserts `mem_wr` and `mem_rd` in the same cycle, and two writes in back-to-back cycles go to consecutive addresses.
- R10: The target changes its SDA drive only while SCL is low.
- R11: During reset the target releases SDA and issues no memory access and no parity error.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | When high the pad pulls SDA low |
| strap | input | 3 | Low three bits of the device address |
| bip_en | input | 1 | Selects the fixed-length parity transfer mode |
| mem_addr | output | 16 | Byte address of the current memory access |
| mem_wr | output | 1 | Write strobe, one byte per cycle |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| bip_err | output | 1 | One-cycle pulse on a parity mismatch in a write |

## Verification
The bound checker watches, on every clock, that SDA drive moves only while SCL is low, that no write lands in the reserved range, that the port never reads and writes at once, that paired writes step by one address, that parity errors appear only in parity mode, and that reset silences the outputs. Address matching, the single-byte discard, range-crossing truncation, auto-increment across a read, and the check byte values on both directions depend on whole bus transfers, so only the bench's scripted transactions, with a scoreboard of expected writes and expected read bytes, can show them.

// File: rtl/i2cp_pkg.sv
// Shared types and helpers for the I2C memory-mapped target.
// Assumes a 16-bit byte address space split into buffer, reserved and
// register ranges by two thresholds passed in by the caller.
package i2cp_pkg;

    typedef enum logic [1:0] {
        RNG_BUF = 2'd0,
        RNG_RSV = 2'd1,
        RNG_REG = 2'd2
    } range_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_AHI  = 3'd1,
        PH_ALO  = 3'd2,
        PH_DATA = 3'd3,
        PH_READ = 3'd4
    } phase_e;

    // Map a byte address to the range it lives in.
    function automatic range_e classify(input logic [15:0] a,
                                        input int unsigned buf_size,
                                        input int unsigned reg_base);
        logic [31:0] wa;
        wa = {16'd0, a};
        if (wa < buf_size)       return RNG_BUF;
        else if (wa >= reg_base) return RNG_REG;
        else                     return RNG_RSV;
    endfunction

endpackage

// File: rtl/i2cp_line_sync.sv
// Brings SCL and SDA into the clock domain and finds edges and bus
// conditions. Assumes the bus idles high; STAGES flops per line.
module i2cp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_s;

    // Synchronizer chains plus one history flop per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q    <= '1;
            sda_q    <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_q    <= {scl_q[STAGES-2:0], scl_i};
            sda_q    <= {sda_q[STAGES-2:0], sda_i};
            scl_prev <= scl_q[STAGES-1];
            sda_prev <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Edges of SCL and SDA transitions while SCL stays high.
    always_comb begin
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_det = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
    end
endmodule

// File: rtl/i2cp_bit_engine.sv
// Bit-level I2C target: shifts bytes in and out, drives ACK on request,
// and samples the controller's ACK on reads. Assumes the transaction
// layer answers ack_req before the SCL fall after the 8th bit and
// answers tx_req with tx_ready while SCL is still low.
module i2cp_bit_engine #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic            ack_req,
    input  logic            tx_ready,
    input  logic [BITS-1:0] tx_byte,
    output logic            rx_valid,
    output logic [BITS-1:0] rx_byte,
    output logic            rx_first,
    output logic            tx_req,
    output logic            sda_oe
);
    localparam int CW = $clog2(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    typedef enum logic [2:0] {
        S_IDLE, S_RX, S_RXEND, S_ACK, S_TXWAIT, S_TX, S_TXACK, S_TXAEND
    } st_e;

    st_e            st;
    logic [BITS-1:0] sh;
    logic [CW-1:0]  cnt;
    logic           first;
    logic           rd_mode;

    assign rx_first = first;

    // Bus bit sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            sh       <= '0;
            cnt      <= '0;
            first    <= 1'b0;
            rd_mode  <= 1'b0;
            sda_oe   <= 1'b0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
            tx_req   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            if (start_det) begin
                st      <= S_RX;
                cnt     <= '0;
                first   <= 1'b1;
                rd_mode <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                st     <= S_IDLE;
                first  <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    S_RX: if (scl_rise) begin
                        sh  <= {sh[BITS-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) begin
                            rx_valid <= 1'b1;
                            rx_byte  <= {sh[BITS-2:0], sda_s};
                            st       <= S_RXEND;
                        end
                    end
                    S_RXEND: if (scl_fall) begin
                        if (ack_req) begin
                            sda_oe <= 1'b1;
                            st     <= S_ACK;
                            if (first) rd_mode <= sh[0];
                        end else begin
                            st <= S_IDLE;
                        end
                        first <= 1'b0;
                    end
                    S_ACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        if (rd_mode) begin
                            tx_req <= 1'b1;
                            st     <= S_TXWAIT;
                        end else begin
                            st <= S_RX;
                        end
                    end
                    S_TXWAIT: if (tx_ready) begin
                        sh     <= tx_byte;
                        sda_oe <= ~tx_byte[BITS-1];
                        cnt    <= '0;
                        st     <= S_TX;
                    end
                    S_TX: if (scl_fall) begin
                        if (cnt == LAST) begin
                            sda_oe <= 1'b0;
                            st     <= S_TXACK;
                        end else begin
                            sda_oe <= ~sh[BITS-2];
                            sh     <= {sh[BITS-2:0], 1'b0};
                            cnt    <= cnt + 1'b1;
                        end
                    end
                    S_TXACK: if (scl_rise) begin
                        st <= sda_s ? S_IDLE : S_TXAEND;
                    end
                    S_TXAEND: if (scl_fall) begin
                        tx_req <= 1'b1;
                        st     <= S_TXWAIT;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cp_txn_ctrl.sv
// Transaction layer: device address match, address phase, write staging
// with single-byte discard and range checks, read fetch, and parity mode.
// Assumes bytes arrive many clocks apart so the two-entry write queue
// always drains before the next push, and mem_rdata is valid one cycle
// after mem_rd.
module i2cp_txn_ctrl
    import i2cp_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter int unsigned BUF_SIZE = 3000,
    parameter int unsigned REG_BASE = 32'hFFDA,
    parameter logic [3:0]  DEV_HI   = 4'b0011
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    strap,
    input  logic          bip_en,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_first,
    input  logic          tx_req,
    input  logic          stop_det,
    input  logic [DW-1:0] mem_rdata,
    output logic          ack_req,
    output logic          tx_ready,
    output logic [DW-1:0] tx_byte,
    output logic [AW-1:0] mem_addr,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_rd,
    output logic          bip_err
);
    localparam int CNTW = 3;
    localparam logic [CNTW-1:0] CNT_MAX = '1;

    phase_e          ph;
    logic [AW-1:0]   ptr;
    logic [DW-1:0]   ahi_q, alo_q, hold0, hold1;
    logic [CNTW-1:0] dcnt;
    logic [1:0]      rcnt;
    logic [DW-1:0]   racc;
    logic            rd_wait;
    range_e          start_rng;
    logic            broken;

    logic            q0_v, q1_v;
    logic [AW-1:0]   q0_a, q1_a;
    logic [DW-1:0]   q0_d, q1_d;

    logic            p0_v, p1_v, bip_bad;
    logic [AW-1:0]   p0_a, p1_a;
    logic [DW-1:0]   p0_d, p1_d;
    logic [AW-1:0]   base;
    logic            data_byte;
    logic            dev_match;

    assign base      = {ahi_q, alo_q};
    assign data_byte = rx_valid && !rx_first && (ph == PH_DATA);
    assign dev_match = (rx_byte[DW-1:1] == {DEV_HI, strap});

    // Decide which received data bytes become memory writes.
    always_comb begin
        p0_v = 1'b0; p0_a = ptr; p0_d = rx_byte;
        p1_v = 1'b0; p1_a = ptr; p1_d = rx_byte;
        bip_bad = 1'b0;
        if (data_byte) begin
            if (bip_en) begin
                if (dcnt == 3'd2) begin
                    if ((ahi_q ^ alo_q ^ hold0 ^ hold1 ^ rx_byte) == '0) begin
                        p0_a = base;
                        p0_d = hold0;
                        p0_v = (classify(base, BUF_SIZE, REG_BASE) != RNG_RSV);
                        p1_a = base + 1'b1;
                        p1_d = hold1;
                        p1_v = p0_v && (classify(base + 1'b1, BUF_SIZE, REG_BASE)
                                        == classify(base, BUF_SIZE, REG_BASE));
                    end else begin
                        bip_bad = 1'b1;
                    end
                end
            end else if (dcnt == 3'd1) begin
                p0_a = ptr - 1'b1;
                p0_d = hold0;
                p0_v = (start_rng != RNG_RSV);
                p1_v = p0_v && (classify(ptr, BUF_SIZE, REG_BASE) == start_rng);
            end else if (dcnt >= 3'd2) begin
                p0_v = !broken && (start_rng != RNG_RSV)
                       && (classify(ptr, BUF_SIZE, REG_BASE) == start_rng);
            end
        end
    end

    // Protocol phase, address pointer and write staging registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            ptr       <= '0;
            ahi_q     <= '0;
            alo_q     <= '0;
            hold0     <= '0;
            hold1     <= '0;
            dcnt      <= '0;
            start_rng <= RNG_BUF;
            broken    <= 1'b0;
            ack_req   <= 1'b0;
            bip_err   <= 1'b0;
        end else begin
            bip_err <= bip_bad;
            if (stop_det) begin
                ph <= PH_IDLE;
            end else if (rx_valid && rx_first) begin
                ack_req <= dev_match;
                dcnt    <= '0;
                broken  <= 1'b0;
                if (!dev_match)      ph <= PH_IDLE;
                else if (rx_byte[0]) ph <= PH_READ;
                else                 ph <= PH_AHI;
            end else if (rx_valid) begin
                ack_req <= 1'b1;
                case (ph)
                    PH_AHI: begin
                        ahi_q          <= rx_byte;
                        ptr[AW-1:DW]   <= rx_byte;
                        ph             <= PH_ALO;
                    end
                    PH_ALO: begin
                        alo_q          <= rx_byte;
                        ptr[DW-1:0]    <= rx_byte;
                        ph             <= PH_DATA;
                    end
                    PH_DATA: begin
                        if (dcnt != CNT_MAX) dcnt <= dcnt + 1'b1;
                        if (dcnt == 3'd0) begin
                            hold0     <= rx_byte;
                            start_rng <= classify(ptr, BUF_SIZE, REG_BASE);
                        end
                        if (dcnt == 3'd1) hold1 <= rx_byte;
                        if (!bip_en) begin
                            ptr <= ptr + 1'b1;
                            if (dcnt >= 3'd1 && !p1_v && !(dcnt >= 3'd2 && p0_v))
                                broken <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (rd_wait) ptr <= ptr + 1'b1;
        end
    end

    // Two-entry write queue draining one byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0_v <= 1'b0; q0_a <= '0; q0_d <= '0;
            q1_v <= 1'b0; q1_a <= '0; q1_d <= '0;
        end else if (p0_v) begin
            q0_v <= 1'b1; q0_a <= p0_a; q0_d <= p0_d;
            q1_v <= p1_v; q1_a <= p1_a; q1_d <= p1_d;
        end else if (q0_v) begin
            q0_v <= q1_v; q0_a <= q1_a; q0_d <= q1_d;
            q1_v <= 1'b0;
        end
    end

    // Read fetch, parity accumulation and byte hand-off to the bit engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd   <= 1'b0;
            rd_wait  <= 1'b0;
            tx_ready <= 1'b0;
            tx_byte  <= '0;
            rcnt     <= '0;
            racc     <= '0;
        end else begin
            mem_rd   <= 1'b0;
            tx_ready <= 1'b0;
            rd_wait  <= mem_rd;
            if (rx_valid && rx_first) begin
                rcnt <= '0;
                racc <= ahi_q ^ alo_q;
            end
            if (rd_wait) begin
                tx_byte  <= mem_rdata;
                tx_ready <= 1'b1;
                racc     <= racc ^ mem_rdata;
            end
            if (tx_req) begin
                if (rcnt != 2'd3) rcnt <= rcnt + 1'b1;
                if (bip_en && rcnt == 2'd2) begin
                    tx_byte  <= racc;
                    tx_ready <= 1'b1;
                end else if (bip_en && rcnt == 2'd3) begin
                    tx_byte  <= '1;
                    tx_ready <= 1'b1;
                end else begin
                    mem_rd <= 1'b1;
                end
            end
        end
    end

    assign mem_wr    = q0_v;
    assign mem_wdata = q0_d;
    assign mem_addr  = q0_v ? q0_a : ptr;
endmodule

// File: rtl/i2cp_target.sv
// Top of the I2C memory-mapped target. Joins line sampling, the bit
// engine and the transaction layer, and exposes a byte memory port.
// Assumes an open-drain pad: sda_oe high pulls SDA low.
module i2cp_target #(
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned BUF_SIZE    = 3000,
    parameter int unsigned REG_BASE    = 32'hFFDA,
    parameter logic [3:0]  DEV_HI      = 4'b0011
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [2:0]  strap,
    input  logic        bip_en,
    output logic [15:0] mem_addr,
    output logic        mem_wr,
    output logic [7:0]  mem_wdata,
    output logic        mem_rd,
    input  logic [7:0]  mem_rdata,
    output logic        bip_err
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       rx_valid, rx_first, tx_req, ack_req, tx_ready;
    logic [7:0] rx_byte, tx_byte;

    i2cp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cp_bit_engine #(.BITS(8)) u_bits (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .ack_req(ack_req), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_first(rx_first),
        .tx_req(tx_req), .sda_oe(sda_oe)
    );

    i2cp_txn_ctrl #(
        .AW(16), .DW(8), .BUF_SIZE(BUF_SIZE), .REG_BASE(REG_BASE), .DEV_HI(DEV_HI)
    ) u_txn (
        .clk(clk), .rst_n(rst_n), .strap(strap), .bip_en(bip_en),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_first(rx_first),
        .tx_req(tx_req), .stop_det(stop_det), .mem_rdata(mem_rdata),
        .ack_req(ack_req), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .bip_err(bip_err)
    );
endmodule

// File: rtl/i2cp_target_chk.sv
// Protocol checker for i2cp_target, attached by bind below. Observes
// ports only and assumes the pad inputs are driven by a legal controller.
module i2cp_target_chk #(
    parameter int unsigned BUF_SIZE = 3000,
    parameter int unsigned REG_BASE = 32'hFFDA
) (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe,
    input logic        bip_en,
    input logic [15:0] mem_addr,
    input logic        mem_wr,
    input logic        mem_rd,
    input logic        bip_err
);
    // R4
    no_reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (({16'd0, mem_addr} < BUF_SIZE) || ({16'd0, mem_addr} >= REG_BASE)));

    // R9
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, mem_rd}));

    // R9
    pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr) && $past(rst_n)) |-> (mem_addr == $past(mem_addr) + 16'd1));

    // R7
    err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bip_err |-> bip_en);

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bip_err |=> !bip_err);

    // R10
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && $past(rst_n)) |-> !scl_i);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !mem_wr && !mem_rd && !bip_err));
endmodule

bind i2cp_target i2cp_target_chk #(.BUF_SIZE(BUF_SIZE), .REG_BASE(REG_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .bip_en(bip_en),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .bip_err(bip_err)
);

// File: tb/i2cp_target_tb.sv
// Scoreboard bench: transaction tasks push expected writes, a monitor pops
// and compares them as the memory port fires; reads compare returned bytes.
module i2cp_target_tb;
    localparam int Q = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0]  strap = 3'b000;
    logic        bip_en = 1'b0;
    logic        sda_oe, mem_wr, mem_rd, bip_err;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        sda_line;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2cp_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap(strap), .bip_en(bip_en), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .bip_err(bip_err)
    );

    int n_chk = 0, n_fail = 0;
    int unexp = 0, overlap = 0, oe_viol = 0, err_cnt = 0;
    logic oe_prev = 1'b0;
    logic [7:0] mem [int];
    logic [23:0] exp_q [$];
    logic [7:0] txb [$];
    logic [7:0] rxb [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Memory model behind the port: one-cycle read latency.
    always @(posedge clk) begin
        if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
        if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    end

    // Monitor: pops expected writes and watches port-level rules.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr) begin
                if (exp_q.size() == 0) begin
                    unexp++;
                    $display("FAIL R2: unexpected write actual 0x%0h expected none",
                             {mem_addr, mem_wdata});
                end else begin
                    logic [23:0] e;
                    e = exp_q.pop_front();
                    check({mem_addr, mem_wdata} == e, "R2 write", {mem_addr, mem_wdata}, e);
                end
            end
            if (mem_wr && mem_rd) overlap++;
            if (bip_err) err_cnt++;
            if (sda_oe !== oe_prev && scl_m) oe_viol++;
            oe_prev = sda_oe;
        end
    end

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
        end
        sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(); sda_m = 1'b1;
    endtask

    // Device address then every byte queued in txb.
    task automatic write_txn(input logic [6:0] dev, output bit dev_ack);
        bit a;
        bus_start();
        put_byte({dev, 1'b0}, dev_ack);
        foreach (txb[i]) put_byte(txb[i], a);
        bus_stop();
        wq(2);
        txb.delete();
    endtask

    task automatic read_txn(input logic [6:0] dev, input logic [15:0] addr, input int n);
        bit a;
        logic [7:0] b;
        rxb.delete();
        bus_start();
        put_byte({dev, 1'b0}, a);
        put_byte(addr[15:8], a);
        put_byte(addr[7:0], a);
        scl_m = 1'b0; sda_m = 1'b1; wq();
        bus_start();
        put_byte({dev, 1'b1}, a);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, b);
            rxb.push_back(b);
        end
        wq();
        check(sda_oe == 1'b0, "R5 release after NACK", sda_oe, 0);
        bus_stop();
        wq(2);
    endtask

    task automatic expect_wr(input logic [15:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic drained(input string req);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        check(unexp == 0, req, unexp, 0);
    endtask

    task automatic finish_run();
        check(overlap == 0, "R9 read/write overlap", overlap, 0);
        check(oe_viol == 0, "R10 SDA change with SCL high", oe_viol, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] bp;
        repeat (4) @(negedge clk);
        // R11: quiet during reset
        check(!sda_oe && !mem_wr && !mem_rd && !bip_err, "R11 reset state",
              {sda_oe, mem_wr, mem_rd, bip_err}, 0);
        rst_n = 1'b1;
        wq(2);

        // R1 + R2: four bytes into the buffer at 0x0010
        txb = '{8'h00, 8'h10, 8'h11, 8'h22, 8'h33, 8'h44};
        for (int i = 0; i < 4; i++) expect_wr(16'h0010 + 16'(i), 8'h11 * 8'(i + 1));
        write_txn(7'h18, ack);
        check(ack, "R1 ack on match", ack, 1);
        drained("R2 burst write");

        // R1: wrong device address, no ack, no write
        txb = '{8'h00, 8'h40, 8'hDE, 8'hAD};
        write_txn(7'h19, ack);
        check(!ack, "R1 nack on mismatch", ack, 0);
        drained("R1 no write on mismatch");

        // R3: single data byte discarded
        txb = '{8'h00, 8'h50, 8'h77};
        write_txn(7'h18, ack);
        drained("R3 single byte dropped");

        // R4: burst running off the end of the buffer
        txb = '{8'h0B, 8'hB6, 8'hA1, 8'hA2, 8'hA3};
        expect_wr(16'h0BB6, 8'hA1);
        expect_wr(16'h0BB7, 8'hA2);
        write_txn(7'h18, ack);
        drained("R4 buffer end truncation");

        // R4: reserved range never written
        txb = '{8'h20, 8'h00, 8'h01, 8'h02};
        write_txn(7'h18, ack);
        drained("R4 reserved range");

        // R4: register write wrapping to 0x0000 keeps only the first byte
        txb = '{8'hFF, 8'hFF, 8'h5A, 8'h6B};
        expect_wr(16'hFFFF, 8'h5A);
        write_txn(7'h18, ack);
        drained("R4 wrap from registers");

        // R5: read back the burst
        read_txn(7'h18, 16'h0010, 4);
        for (int i = 0; i < 4; i++)
            check(rxb[i] == 8'h11 * 8'(i + 1), "R5 read data", rxb[i], 8'h11 * (i + 1));

        // R6: parity write with trailing extra byte
        bip_en = 1'b1;
        bp = 8'h00 ^ 8'h20 ^ 8'hA5 ^ 8'h3C;
        txb = '{8'h00, 8'h20, 8'hA5, 8'h3C, bp, 8'h99};
        expect_wr(16'h0020, 8'hA5);
        expect_wr(16'h0021, 8'h3C);
        write_txn(7'h18, ack);
        drained("R6 parity write");
        check(err_cnt == 0, "R6 no error on good parity", err_cnt, 0);

        // R7: bad parity writes nothing and pulses the error
        txb = '{8'h00, 8'h20, 8'h01, 8'h02, bp};
        write_txn(7'h18, ack);
        drained("R7 bad parity no write");
        check(err_cnt == 1, "R7 error pulse", err_cnt, 1);

        // R8: parity read returns data and check byte
        read_txn(7'h18, 16'h0020, 3);
        check(rxb[0] == 8'hA5, "R8 data0", rxb[0], 8'hA5);
        check(rxb[1] == 8'h3C, "R8 data1", rxb[1], 8'h3C);
        check(rxb[2] == bp, "R8 check byte", rxb[2], bp);
        bip_en = 1'b0;

        // R1: straps move the address to 0x1D
        strap = 3'b101;
        txb = '{8'h01, 8'h00, 8'hC1, 8'hC2};
        expect_wr(16'h0100, 8'hC1);
        expect_wr(16'h0101, 8'hC2);
        write_txn(7'h1D, ack);
        check(ack, "R1 strap address", ack, 1);
        drained("R1 strap write");

        finish_run();
    end
endmodule